// File: doc/BRIEF.md
# Processor Boot Strap and Reset Sequencer

This block sits in the FPGA beside an attached processor and controls how that processor starts. While the FPGA is still configuring, the processor's reset input is held low and its three boot-mode strap pins are left undriven. When the FPGA signals that it is configured, the block drives the strap levels that select booting from the external memory bus. It holds those levels for a set number of clocks and then releases the processor from reset. It keeps the straps driven for a second set interval after the release, to meet the hold time, and then lets them go to high impedance.

Once the processor is out of reset, the block acts as its first-stage boot memory. The processor fetches 256 words of 32 bits (1 KB) through a simple synchronous read port. The block returns a fixed image that is computed into logic at build time. Reads outside that window return zero. The block counts accepted reads inside the window. After the 256th such read it raises a completion flag, which stays high until the block is reset.

Top module: `cpu_boot_sequencer`

## Requirements
- R1: While rstN is low, cpuResetN is 0, strapEn is 0, strapLvl is 0 and bootDone is 0.
- R2: While cfgDone stays low after reset, cpuResetN stays 0 and strapEn stays 0.
- R3: While strapEn is 1, strapLvl is 3'b100: bit 2 (serial data-out strap) is high, and bit 1 (serial clock strap) and bit 0 (serial data-in strap) are low.
- R4: cpuResetN never rises unless strapEn is already 1. After cfgDone is seen high, strapEn is 1 with cpuResetN 0 for exactly SETUP_CYC+1 clock cycles, and then cpuResetN goes to 1.
- R5: After cpuResetN rises, strapEn stays 1 for exactly HOLD_CYC+1 cycles with cpuResetN at 1. Then strapEn drops to 0 and cpuResetN stays 1.
- R6: In the serving phase, a read with rdAddr below WORDS returns 32'hB0070000 | (rdAddr << 8) | (rdAddr ^ 8'hFF) on rdData. The data appears one clock after rdEn is sampled.
- R7: In the serving phase, a read with rdAddr at or above WORDS returns 0 and does not count toward completion.
- R8: A read made while cpuResetN is still 0 returns 0.
- R9: bootDone rises in the same cycle that the data of the WORDS-th in-window read appears. It then stays high, and in-window reads still return image data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rstN | input | 1 | Active-low reset of the sequencer |
| cfgDone | input | 1 | High once the FPGA has finished configuring |
| cpuResetN | output | 1 | Active-low reset to the processor |
| strapEn | output | 1 | Output enable of the three strap pins |
| strapLvl | output | 3 | Strap levels: [2] data-out, [1] clock, [0] data-in |
| rdEn | input | 1 | Read strobe from the bus slave |
| rdAddr | input | ADDR_W | Word address of the read |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| bootDone | output | 1 | First-stage image fully fetched |

## Verification
Read data and bootDone are due at the first falling edge after the rising edge that samples rdEn. Each read task therefore drives on one falling edge and samples on the next. Strap and reset levels are Moore outputs of the sequencing state, so they change one edge after the condition that causes the change. The bench counts falling edges phase by phase and compares the number of cycles with straps driven before and after the reset release against SETUP_CYC+1 and HOLD_CYC+1.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int DATA_W = 32;
  localparam logic [2:0] STRAP_LEVELS = 3'b100;

  typedef enum logic [2:0] {
    S_WAIT_CFG, S_DRIVE, S_SETUP, S_RELEASE, S_HOLD, S_SERVE, S_DONE
  } seqState_t;

  typedef struct packed {
    logic tmrClear;
    logic tmrSelHold;
    logic serveEn;
    logic countEn;
  } dpCtl_t;

  function automatic logic [DATA_W-1:0] romWord(input logic [7:0] idx);
    return {16'hB007, idx, ~idx};
  endfunction
endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cfgDone,
  input  logic   tmrDone,
  input  logic   lastHit,
  output dpCtl_t ctl,
  output logic   cpuResetN,
  output logic   strapEn,
  output logic   bootDone
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_WAIT_CFG;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_WAIT_CFG: if (cfgDone) nextState = S_DRIVE;
      S_DRIVE:    nextState = S_SETUP;
      S_SETUP:    if (tmrDone) nextState = S_RELEASE;
      S_RELEASE:  nextState = S_HOLD;
      S_HOLD:     if (tmrDone) nextState = S_SERVE;
      S_SERVE:    if (lastHit) nextState = S_DONE;
      S_DONE:     nextState = S_DONE;
      default:    nextState = S_WAIT_CFG;
    endcase
  end

  always_comb begin
    ctl.tmrClear   = !(state == S_SETUP || state == S_HOLD);
    ctl.tmrSelHold = (state == S_HOLD);
    ctl.serveEn    = (state == S_SERVE || state == S_DONE);
    ctl.countEn    = (state == S_SERVE);
  end

  assign strapEn   = (state == S_DRIVE) || (state == S_SETUP) ||
                     (state == S_RELEASE) || (state == S_HOLD);
  assign cpuResetN = (state == S_RELEASE) || (state == S_HOLD) ||
                     (state == S_SERVE) || (state == S_DONE);
  assign bootDone  = (state == S_DONE);
endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int WORDS     = 256,
  parameter int ADDR_W    = 14,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              tmrDone,
  output logic              lastHit
);
  localparam int TMR_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CNT_W   = $clog2(WORDS);

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] readCnt;
  logic             inWindow, countHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tmr <= '0;
    else if (ctl.tmrClear) tmr <= '0;
    else                   tmr <= tmr + 1'b1;
  end

  assign tmrDone = ctl.tmrSelHold ? (tmr == TMR_W'(HOLD_CYC - 1))
                                  : (tmr == TMR_W'(SETUP_CYC - 1));

  assign inWindow = ({1'b0, rdAddr} < (ADDR_W + 1)'(WORDS));
  assign countHit = rdEn && ctl.countEn && inWindow;
  assign lastHit  = countHit && (readCnt == CNT_W'(WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         readCnt <= '0;
    else if (countHit) readCnt <= readCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn)
      rdData <= (ctl.serveEn && inWindow) ? romWord(8'(rdAddr[CNT_W-1:0])) : '0;
  end
endmodule

// File: rtl/cpu_boot_sequencer.sv
module cpu_boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int WORDS     = 256,
  parameter int ADDR_W    = 14,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDone,
  output logic              cpuResetN,
  output logic              strapEn,
  output logic [2:0]        strapLvl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              bootDone
);
  dpCtl_t ctl;
  logic   tmrDone, lastHit;

  boot_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .tmrDone(tmrDone),
    .lastHit(lastHit), .ctl(ctl), .cpuResetN(cpuResetN),
    .strapEn(strapEn), .bootDone(bootDone)
  );

  boot_seq_dp #(
    .WORDS(WORDS), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .tmrDone(tmrDone), .lastHit(lastHit)
  );

  assign strapLvl = strapEn ? STRAP_LEVELS : 3'b000;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgDone,
  input logic        cpuResetN,
  input logic        strapEn,
  input logic [2:0]  strapLvl,
  input logic        rdEn,
  input logic [31:0] rdData,
  input logic        bootDone
);
  // R2
  cfg_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDone && !strapEn && !cpuResetN) |=> !cpuResetN);
  // R3
  strap_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    strapEn |-> (strapLvl == 3'b100));
  // R4
  reset_after_strap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuResetN) |-> strapEn);
  // R5
  strap_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strapEn) |-> cpuResetN);
  // R8
  early_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !cpuResetN) |=> (rdData == 32'h0));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> bootDone);
endmodule

bind cpu_boot_sequencer boot_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .cpuResetN(cpuResetN),
  .strapEn(strapEn), .strapLvl(strapLvl), .rdEn(rdEn), .rdData(rdData),
  .bootDone(bootDone)
);

// File: tb/test_cpu_boot_sequencer.sv
module test_cpu_boot_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;
  localparam int ADDR_W = 14;
  localparam int SETUP = 5;
  localparam int HOLD = 3;
  localparam int NVEC = 6;
  // {address, expected data}
  localparam logic [45:0] VEC [NVEC] = '{
    {14'h0000, 32'hB00700FF}, {14'h0001, 32'hB00701FE},
    {14'h00FF, 32'hB007FF00}, {14'h0080, 32'hB007807F},
    {14'h0100, 32'h00000000}, {14'h3FFF, 32'h00000000}
  };

  logic clk = 0, rstN = 0, cfgDone = 0, rdEn = 0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic cpuResetN, strapEn, bootDone;
  logic [2:0] strapLvl;
  logic [31:0] rdData;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_boot_sequencer #(.WORDS(WORDS), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD))
    i_cpu_boot_sequencer (.clk(clk), .rstN(rstN), .cfgDone(cfgDone), .cpuResetN(cpuResetN),
      .strapEn(strapEn), .strapLvl(strapLvl), .rdEn(rdEn), .rdAddr(rdAddr),
      .rdData(rdData), .bootDone(bootDone));

  function automatic logic [31:0] expWord(input int a);
    if (a >= WORDS) return 32'h0;
    return 32'hB0070000 | (32'(a) << 8) | 32'((a & 8'hFF) ^ 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input int a);
    rdEn = 1; rdAddr = ADDR_W'(a);
    @(negedge clk);
    rdEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, setupCnt, holdCnt;
    logic bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {28'h0, cpuResetN, strapEn, bootDone, |strapLvl}, 32'h0);
    rstN = 1;
    @(negedge clk);
    // R8 read before reset release
    doRead(5);
    check("R8", rdData, 32'h0);
    // R2 waiting for configuration
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (cpuResetN || strapEn) bad = 1;
    end
    check("R2", {31'h0, bad}, 32'h0);
    cfgDone = 1;
    n = 0;
    @(negedge clk);
    while (!strapEn && !cpuResetN && n < 10) begin n++; @(negedge clk); end
    bad = 0; setupCnt = 0;
    while (strapEn && !cpuResetN && setupCnt < 100) begin
      if (strapLvl != 3'b100) bad = 1;
      setupCnt++; @(negedge clk);
    end
    // R4 setup interval, reset rises only while straps driven
    check("R4", 32'(setupCnt), 32'(SETUP + 1));
    check("R4", {30'h0, cpuResetN, strapEn}, 32'h3);
    holdCnt = 0;
    while (strapEn && cpuResetN && holdCnt < 100) begin
      if (strapLvl != 3'b100) bad = 1;
      holdCnt++; @(negedge clk);
    end
    // R5 hold interval then release
    check("R5", 32'(holdCnt), 32'(HOLD + 1));
    check("R5", {30'h0, cpuResetN, strapEn}, 32'h2);
    // R3 strap levels throughout
    check("R3", {31'h0, bad}, 32'h0);
    // R6 / R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      doRead(int'(VEC[i][45:32]));
      check(VEC[i][45:32] < WORDS ? "R6" : "R7", rdData, VEC[i][31:0]);
    end
    bad = 0;
    for (int a = 0; a < 251; a++) begin
      doRead(a);
      if (rdData !== expWord(a)) bad = 1;
    end
    check("R6", {31'h0, bad}, 32'h0);
    check("R9", {31'h0, bootDone}, 32'h0);
    doRead(300);
    // R7 out-of-window read not counted
    check("R7", rdData, 32'h0);
    check("R7", {31'h0, bootDone}, 32'h0);
    doRead(7);
    // R9 done with the last word's data
    check("R9", rdData, expWord(7));
    check("R9", {31'h0, bootDone}, 32'h1);
    doRead(9);
    check("R9", {rdData[31:1], bootDone}, {expWord(9)[31:1], 1'b1});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule